// File: doc/BRIEF.md
# Rate-Selectable Parallel-to-Serial Word Converter

This block turns an 8-bit parallel word into a serial bit stream, bit 0 first and bit 7 last. A rate-select pin chooses between one serial bit per clock cycle (full rate) and two serial bits per clock cycle (half rate, one bit in each clock phase). A word clock output runs at one eighth of the serial bit rate. It rises in the cycle a new word is taken from the parallel input, so the data source can use it to pace its words.

A level-sensitive sync input clears the block at once when it rises. Once it falls, the block waits for the next falling clock edge and starts converting at the rising edge after that. A conversion-enable input stops and resumes conversion at rising clock edges. For synthesis, the two bits of each half-rate cycle are given as an ordered pair. The combined serial output, which selects from the pair by clock level, is kept for simulation checking.

Top module: `octet_serializer`

## Requirements
- R1: Each word is sent in order din[0], din[1], ..., din[7], with din[0] in the first serial bit slot after the word is captured.
- R2: With rate_full = 1, one bit is sent per clock cycle: pair_first and pair_second both carry that bit, and ser_out holds it for the whole cycle.
- R3: With rate_full = 0, two bits are sent per clock cycle: pair_first carries the lower-indexed bit and appears on ser_out while clk is high, and pair_second carries the next bit and appears on ser_out while clk is low.
- R4: word_clk is high while the first four bits of a word are on the output and low for the last four bits. Its period is 8 clock cycles at full rate and 4 at half rate, and it rises only in the cycle a word is captured.
- R5: din is sampled only at the rising edge that starts a word. Its value at any other edge has no effect, and successive words follow with no gap or repeated bit.
- R6: While sync_hold is high, pair_first, pair_second, ser_out and word_clk are 0. A rise of sync_hold clears them at once, without waiting for a clock edge.
- R7: After sync_hold falls, the first bit of a word appears after the rising clock edge that follows the next falling clock edge.
- R8: When conv_en is low at a rising edge, the outputs go to 0 and word_clk goes low after that edge. When conv_en is high again, conversion starts a fresh word from din at bit 0.
- R9: ser_out_n is always the complement of ser_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| sync_hold | input | 1 | Active-high asynchronous clear; conversion restarts after it falls |
| conv_en | input | 1 | Conversion enable, sampled on rising clk |
| rate_full | input | 1 | 1: one bit per cycle; 0: two bits per cycle |
| din | input | 8 | Parallel word |
| pair_first | output | 1 | Bit for the high clock phase |
| pair_second | output | 1 | Bit for the low clock phase (equals pair_first at full rate) |
| ser_out | output | 1 | Combined serial bit, selected by clock level |
| ser_out_n | output | 1 | Complement of ser_out |
| word_clk | output | 1 | Word-rate clock; rises when a word is captured |

## Verification
The converter is driven with a parallel input that changes on every clock. A model that samples din at the wrong edge therefore sends different bits from one that samples only at word start. Fixed words (0x01, 0x80, 0xFF, 0x00) show where each single bit lands in the stream and whether bits are reversed or misplaced. The same streams are sent at both rates. Enable drops and sync pulses are placed in the middle of words to test the clear, the restart timing and the fresh-word start.

// File: rtl/ser8_pkg.sv
// Package: shared rate encoding for the word serializer.
// Assumes: rate select pin is 1 for one bit per clock, 0 for two.
package ser8_pkg;
    typedef enum logic {
        RATE_HALF = 1'b0,
        RATE_FULL = 1'b1
    } rate_e;
endpackage

// File: rtl/ser8_arm.sv
// Module: restart arming flop.
// Cleared at once by sync_hold; sets on the first falling clk edge
// after sync_hold is low, so conversion begins at the next rising edge.
module ser8_arm (
    input  logic clk,
    input  logic sync_hold,
    output logic armed
);
    // Purpose: arm on falling clk, clear asynchronously on sync_hold.
    always_ff @(negedge clk or posedge sync_hold) begin
        if (sync_hold) armed <= 1'b0;
        else           armed <= 1'b1;
    end
endmodule

// File: rtl/ser8_sequencer.sv
// Module: slot sequencer and word clock.
// Counts output slots within a word (8 at full rate, 4 at half rate),
// flags the capture slot and drives the registered word clock.
// Assumes WORD_W is a multiple of 4.
module ser8_sequencer #(
    parameter int WORD_W = 8,
    localparam int PH_W  = $clog2(WORD_W)
) (
    input  logic            clk,
    input  logic            sync_hold,
    input  logic            go,
    input  logic            rate_full,
    output logic [PH_W-1:0] phase,
    output logic            capture,
    output logic            wclk_q
);
    localparam logic [PH_W-1:0] LAST_FULL = PH_W'(WORD_W - 1);
    localparam logic [PH_W-1:0] LAST_HALF = PH_W'(WORD_W / 2 - 1);
    localparam logic [PH_W-1:0] HI_FULL   = PH_W'(WORD_W / 2);
    localparam logic [PH_W-1:0] HI_HALF   = PH_W'(WORD_W / 4);

    logic [PH_W-1:0] last_slot;
    logic [PH_W-1:0] hi_slots;

    // Purpose: pick the slot limits for the selected rate.
    always_comb begin
        last_slot = rate_full ? LAST_FULL : LAST_HALF;
        hi_slots  = rate_full ? HI_FULL   : HI_HALF;
        capture   = go && (phase == '0);
    end

    // Purpose: advance the slot counter and register the word clock.
    always_ff @(posedge clk or posedge sync_hold) begin
        if (sync_hold) begin
            phase  <= '0;
            wclk_q <= 1'b0;
        end else if (!go) begin
            phase  <= '0;
            wclk_q <= 1'b0;
        end else begin
            wclk_q <= (phase < hi_slots);
            phase  <= (phase >= last_slot) ? '0 : phase + 1'b1;
        end
    end

    // R4
    word_period_chk: assert property (@(posedge clk) disable iff (sync_hold)
        (go && $past(go) && rate_full && $past(rate_full) && phase == '0)
        |-> ($past(phase) == LAST_FULL));
endmodule

// File: rtl/ser8_datapath.sv
// Module: word register and output bit pair.
// Loads the word at the capture slot and registers the pair of bits
// for the current slot (both equal at full rate).
module ser8_datapath #(
    parameter int WORD_W = 8,
    localparam int PH_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              sync_hold,
    input  logic              go,
    input  logic              capture,
    input  logic              rate_full,
    input  logic [PH_W-1:0]   phase,
    input  logic [WORD_W-1:0] din,
    output logic              bit_a,
    output logic              bit_b
);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] src;
    logic [PH_W-1:0]   idx_a;
    logic [PH_W-1:0]   idx_b;

    // Purpose: choose the source word and the bit indices for this slot.
    always_comb begin
        src   = capture ? din : word_q;
        idx_a = rate_full ? phase : PH_W'({phase, 1'b0});
        idx_b = rate_full ? idx_a : (idx_a | PH_W'(1));
    end

    // Purpose: hold the captured word.
    always_ff @(posedge clk or posedge sync_hold) begin
        if (sync_hold)    word_q <= '0;
        else if (capture) word_q <= din;
    end

    // Purpose: register the output bit pair; zero when idle.
    always_ff @(posedge clk or posedge sync_hold) begin
        if (sync_hold || !go) begin
            bit_a <= 1'b0;
            bit_b <= 1'b0;
        end else begin
            bit_a <= src[idx_a];
            bit_b <= src[idx_b];
        end
    end
endmodule

// File: rtl/octet_serializer.sv
// Module: rate-selectable 8:1 serializer top.
// Storage updates on rising clk; the combined serial output selects
// the second bit of the pair while clk is low (half rate only).
// Assumes rate_full is changed only while sync_hold or !conv_en.
module octet_serializer #(
    parameter int WORD_W = 8,
    localparam int PH_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              sync_hold,
    input  logic              conv_en,
    input  logic              rate_full,
    input  logic [WORD_W-1:0] din,
    output logic              pair_first,
    output logic              pair_second,
    output logic              ser_out,
    output logic              ser_out_n,
    output logic              word_clk
);
    import ser8_pkg::*;

    logic            armed;
    logic            go;
    logic            capture;
    logic [PH_W-1:0] phase;
    rate_e           rate;

    // Purpose: conversion runs when armed and enabled.
    always_comb begin
        rate = rate_e'(rate_full);
        go   = armed && conv_en;
    end

    ser8_arm i_arm (
        .clk       (clk),
        .sync_hold (sync_hold),
        .armed     (armed)
    );

    ser8_sequencer #(.WORD_W(WORD_W)) i_seq (
        .clk       (clk),
        .sync_hold (sync_hold),
        .go        (go),
        .rate_full (rate == RATE_FULL),
        .phase     (phase),
        .capture   (capture),
        .wclk_q    (word_clk)
    );

    ser8_datapath #(.WORD_W(WORD_W)) i_dp (
        .clk       (clk),
        .sync_hold (sync_hold),
        .go        (go),
        .capture   (capture),
        .rate_full (rate == RATE_FULL),
        .phase     (phase),
        .din       (din),
        .bit_a     (pair_first),
        .bit_b     (pair_second)
    );

    // Purpose: combined serial output, second bit in the low clk phase.
    always_comb begin
        ser_out   = (rate == RATE_HALF && !clk) ? pair_second : pair_first;
        ser_out_n = !ser_out;
    end

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (sync_hold)
        !go |=> (!pair_first && !pair_second && !word_clk));

    // R4
    wclk_capture_chk: assert property (@(posedge clk) disable iff (sync_hold)
        $rose(word_clk) |-> $past(capture));

    // R2
    full_pair_chk: assert property (@(posedge clk) disable iff (sync_hold)
        (go && rate_full) |=> (pair_first == pair_second));
endmodule

// File: tb/test_octet_serializer.sv
`timescale 1ns/100ps
module test_octet_serializer;
    logic       clk = 1'b0;
    logic       sync_hold = 1'b1;
    logic       conv_en = 1'b0;
    logic       rate_full = 1'b1;
    logic [7:0] din = 8'h00;
    logic       pair_first, pair_second, ser_out, ser_out_n, word_clk;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // reference model state
    bit  armed_m = 1'b0;
    bit  q[$];
    bit  e1 = 1'b0, e2 = 1'b0, ew = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    string scen = "R6 reset";

    octet_serializer i_octet_serializer (
        .clk(clk), .sync_hold(sync_hold), .conv_en(conv_en),
        .rate_full(rate_full), .din(din), .pair_first(pair_first),
        .pair_second(pair_second), .ser_out(ser_out),
        .ser_out_n(ser_out_n), .word_clk(word_clk)
    );

    always #2 clk = ~clk;

    task automatic chk(input string what, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got %b exp %b at %0t", scen, what, got, exp, $time);
        end
    endtask

    // model step at a rising edge using inputs held through the cycle
    task automatic model_edge();
        bit go_m;
        go_m = armed_m && conv_en;
        if (!go_m) begin
            q.delete();
            e1 = 0; e2 = 0; ew = 0;
        end else begin
            if (q.size() == 0)
                for (int i = 0; i < 8; i++) q.push_back(din[i]);
            ew = (q.size() > 4);
            e1 = q.pop_front();
            e2 = rate_full ? e1 : q.pop_front();
        end
    endtask

    task automatic cycle(input logic s, input logic e, input logic r, input logic [7:0] d);
        @(posedge clk);
        model_edge();
        #1;
        chk("R1 pair_first", pair_first, e1);
        chk(rate_full ? "R2 pair_second" : "R3 pair_second", pair_second, e2);
        chk("R4 word_clk", word_clk, ew);
        chk("R2 ser_out high phase", ser_out, e1);
        chk("R9 ser_out_n", ser_out_n, ~e1);
        sync_hold = s; conv_en = e; rate_full = r; din = d;
        if (s) begin
            q.delete(); e1 = 0; e2 = 0; ew = 0;
            #0.2;
            chk("R6 async clear first", pair_first, 1'b0);
            chk("R6 async clear second", pair_second, 1'b0);
            chk("R6 async clear wclk", word_clk, 1'b0);
        end
        armed_m = !s;
        @(negedge clk);
        #1;
        chk("R3 ser_out low phase", ser_out, rate_full ? e1 : e2);
        chk("R9 ser_out_n low", ser_out_n, rate_full ? ~e1 : ~e2);
    endtask

    task automatic run_lfsr(input int n, input logic r);
        for (int k = 0; k < n; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cycle(1'b0, 1'b1, r, lfsr);
        end
    endtask

    task automatic run_fixed(input int n, input logic r, input logic [7:0] d);
        for (int k = 0; k < n; k++) cycle(1'b0, 1'b1, r, d);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) cycle(1'b1, 1'b0, 1'b1, 8'hC3);
        scen = "R7 start full";
        run_lfsr(3, 1'b1);
        scen = "R5 R1 full lfsr";
        run_lfsr(40, 1'b1);
        scen = "R1 full fixed";
        run_fixed(8, 1'b1, 8'h01);
        run_fixed(8, 1'b1, 8'h80);
        run_fixed(8, 1'b1, 8'hFF);
        run_fixed(8, 1'b1, 8'h00);
        scen = "R8 enable drop full";
        run_lfsr(3, 1'b1);
        for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, 1'b1, 8'hE7);
        run_lfsr(20, 1'b1);
        scen = "R6 sync mid-word";
        cycle(1'b1, 1'b1, 1'b0, 8'h3C);
        cycle(1'b1, 1'b1, 1'b0, 8'h3C);
        scen = "R7 R3 half lfsr";
        run_lfsr(40, 1'b0);
        scen = "R3 half fixed";
        run_fixed(4, 1'b0, 8'h01);
        run_fixed(4, 1'b0, 8'h80);
        run_fixed(4, 1'b0, 8'hA5);
        scen = "R8 enable drop half";
        run_lfsr(1, 1'b0);
        for (int k = 0; k < 2; k++) cycle(1'b0, 1'b0, 1'b0, 8'h99);
        run_lfsr(16, 1'b0);
        scen = "R6 back to full";
        cycle(1'b1, 1'b0, 1'b1, 8'h00);
        scen = "R5 full after restart";
        run_lfsr(24, 1'b1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 got hung exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule